// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a byte-wide shift register. A full word is placed into it from a parallel input bus and then moved out one bit per shift, so the most significant input bit is seen first. Each shift also takes one new bit from a serial input into the lowest stage. Only the top stage is visible outside the block, as a true output and its complement.

Loading is level-controlled by an active-low load input. While the load input is low, the visible output follows the top bit of the parallel bus at once, with no clock edge needed, and the stages capture the bus on every system clock. Shifting is started by either of two external shift clock inputs. They are OR-combined, brought into the system clock domain and edge-detected, so each low-to-high change of their OR gives exactly one shift. A shift clock input that is not in use must be held low, which makes the other input act as a gated shift clock.

Top module: `piso_shift_reg`

## Requirements
- R1: While the reset input is low, all stages are cleared. After reset, with the load input high, `tail_out` is 0 and `tail_out_n` is 1.
- R2: While `load_n` is low, `tail_out` equals `par_in[WIDTH-1]` without waiting for any clock edge. The stages take `par_in` on each system clock. After `load_n` returns high, the last captured word is kept even if `par_in` then changes.
- R3: On a shift, stage 0 takes `ser_in` and every stage i above 0 takes the old value of stage i-1. After a load of `par_in` (bit i maps to stage i), successive shifts show at `tail_out` bits 6 down to 0 of the loaded word, followed by the `ser_in` values in the order they were shifted in.
- R4: With the default two synchronizer stages, a shift clock input that rises between system clock edges first changes `tail_out` at the third rising system clock edge after it rises. `tail_out` is unchanged at the second edge.
- R5: `shclk_b` alone, with `shclk_a` held low, produces shifts in the same way as `shclk_a` alone.
- R6: Each 0-to-1 change of (`shclk_a` OR `shclk_b`) produces exactly one shift. Holding the OR high causes no further shift. Raising the second input while the first is already high causes no further shift.
- R7: While `load_n` is low, shifting is suppressed. A rising shift clock seen during the load is discarded and not deferred: if the shift clock stays high across the release of `load_n`, no shift follows the release.
- R8: `tail_out_n` is always the logical complement of `tail_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | Free-running system clock that samples the shift clocks |
| rst_sys_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| par_in | input | WIDTH | Parallel word; bit i goes to stage i |
| ser_in | input | 1 | Serial bit taken into stage 0 on each shift |
| load_n | input | 1 | Active-low parallel load, level-controlled |
| shclk_a | input | 1 | Shift clock input A (rising change shifts) |
| shclk_b | input | 1 | Shift clock input B, OR-combined with A |
| tail_out | output | 1 | Top stage value (or `par_in[WIDTH-1]` during load) |
| tail_out_n | output | 1 | Complement of `tail_out` |

## Verification
The bench builds the block with its defaults: an 8-stage chain and a two-flop synchronizer. With these values a whole loaded byte and the serial bits after it can be pushed through `tail_out` in a short run. The three-edge shift latency falls at a fixed, countable system clock edge, so the bench can sample just before and just after it. The bench also places shift clock edges inside a load window and keeps a shift clock high across the release of the load. This brings the discard-not-defer rule and the overlap of both shift clock inputs within reach.

// File: rtl/piso_pkg.sv
package piso_pkg;

  localparam int NUM_SHCLK = 2;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } stage_op_e;

  // Load wins over shift; a shift needs a detected rising shift clock.
  function automatic stage_op_e pick_op(input logic load_low, input logic shift_rise);
    if (load_low)        return OP_LOAD;
    else if (shift_rise) return OP_SHIFT;
    else                 return OP_HOLD;
  endfunction

endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign pipe_d[g] = d_async;
      end else begin : g_rest
        assign pipe_d[g] = pipe_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/piso_edge.sv
module piso_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/piso_chain.sv
module piso_chain
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stage_op_e        op,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  input  logic             load_n,
  output logic [WIDTH-1:0] stage_q,
  output logic             tail
);
  logic [WIDTH-1:0] stage_d;
  logic             stage_en;

  always_comb begin
    stage_d  = stage_q;
    stage_en = 1'b0;
    unique case (op)
      OP_LOAD: begin
        stage_d  = par_in;
        stage_en = 1'b1;
      end
      OP_SHIFT: begin
        stage_d  = {stage_q[WIDTH-2:0], ser_in};
        stage_en = 1'b1;
      end
      default: begin
        stage_d  = stage_q;
        stage_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_en) stage_q <= stage_d;
  end

  // Level-driven load: the top bit bypasses the register while load is low.
  assign tail = load_n ? stage_q[WIDTH-1] : par_in[WIDTH-1];
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
  import piso_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_sys,
  input  logic             rst_sys_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  input  logic             load_n,
  input  logic             shclk_a,
  input  logic             shclk_b,
  output logic             tail_out,
  output logic             tail_out_n
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_n_q;
  logic                  shclk_any;
  logic                  shclk_sync;
  logic                  shclk_rise;
  stage_op_e             op_sel;
  logic [WIDTH-1:0]      stage_q;
  logic                  tail_w;

  // Reset: asserted asynchronously, released on the system clock.
  always_ff @(posedge clk_sys or negedge rst_sys_n) begin
    if (!rst_sys_n) rst_pipe_q <= '0;
    else            rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_q = rst_pipe_q[RST_STAGES-1];

  // Combine the shift clocks first so only one synchronizer is needed.
  assign shclk_any = shclk_a | shclk_b;

  piso_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk_sys),
    .rst_n   (rst_n_q),
    .d_async (shclk_any),
    .q_sync  (shclk_sync)
  );

  piso_edge edge_i (
    .clk   (clk_sys),
    .rst_n (rst_n_q),
    .level (shclk_sync),
    .rise  (shclk_rise)
  );

  assign op_sel = pick_op(~load_n, shclk_rise);

  piso_chain #(.WIDTH(WIDTH)) chain_i (
    .clk     (clk_sys),
    .rst_n   (rst_n_q),
    .op      (op_sel),
    .par_in  (par_in),
    .ser_in  (ser_in),
    .load_n  (load_n),
    .stage_q (stage_q),
    .tail    (tail_w)
  );

  assign tail_out   = tail_w;
  assign tail_out_n = ~tail_w;
endmodule

// File: rtl/piso_checker.sv
module piso_checker
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk_sys,
  input logic             rst_n_q,
  input logic             load_n,
  input logic [WIDTH-1:0] par_in,
  input logic             ser_in,
  input stage_op_e        op_sel,
  input logic [WIDTH-1:0] stage_q
);
  // R2: a low load level lands the parallel word in the stages.
  assert_load_capture_R2: assert property (@(posedge clk_sys) disable iff (!rst_n_q)
    (!load_n) |=> (stage_q == $past(par_in)));

  // R3: a shift moves every stage up one place and takes the serial bit.
  assert_shift_move_R3: assert property (@(posedge clk_sys) disable iff (!rst_n_q)
    (op_sel == OP_SHIFT) |=> (stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)}));

  // R6: one rising shift clock never yields two shifts in a row.
  assert_single_shift_R6: assert property (@(posedge clk_sys) disable iff (!rst_n_q)
    (op_sel == OP_SHIFT) |=> (op_sel != OP_SHIFT));

  // R6: with no load and no detected edge the stages do not move.
  assert_hold_still_R6: assert property (@(posedge clk_sys) disable iff (!rst_n_q)
    (op_sel == OP_HOLD) |=> $stable(stage_q));

  // R7: no shift is chosen while the load level is low.
  assert_no_shift_in_load_R7: assert property (@(posedge clk_sys) disable iff (!rst_n_q)
    (!load_n) |=> ($past(op_sel) != OP_SHIFT));
endmodule

bind piso_shift_reg piso_checker #(.WIDTH(WIDTH)) chk_i (
  .clk_sys (clk_sys),
  .rst_n_q (rst_n_q),
  .load_n  (load_n),
  .par_in  (par_in),
  .ser_in  (ser_in),
  .op_sel  (op_sel),
  .stage_q (stage_q)
);

// File: tb/piso_shift_reg_tb_top.sv
`timescale 1ns/100ps
module piso_shift_reg_tb_top;
  localparam int W = 8;

  logic         clk_sys = 1'b0;
  logic         rst_sys_n;
  logic [W-1:0] par_in;
  logic         ser_in;
  logic         load_n;
  logic         shclk_a;
  logic         shclk_b;
  logic         tail_out;
  logic         tail_out_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  bit    exp_q[$];
  string tag_q[$];
  event  chk_ev;

  // Expected output stream: loaded bits from the top down, then serial bits.
  bit stream[$];

  always #2.5 clk_sys = ~clk_sys;

  piso_shift_reg #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
    .clk_sys    (clk_sys),
    .rst_sys_n  (rst_sys_n),
    .par_in     (par_in),
    .ser_in     (ser_in),
    .load_n     (load_n),
    .shclk_a    (shclk_a),
    .shclk_b    (shclk_b),
    .tail_out   (tail_out),
    .tail_out_n (tail_out_n)
  );

  task automatic check(input string tag, input bit exp);
    n_checks++;
    if (tail_out !== exp) begin
      n_fails++;
      $display("FAIL %s: tail_out=%b expected %b", tag, tail_out, exp);
    end
    if (tail_out_n !== ~exp) begin
      n_fails++;
      $display("FAIL R8 (%s): tail_out_n=%b expected %b", tag, tail_out_n, ~exp);
    end
  endtask

  // Monitor: pops expected items and compares them with the outputs.
  initial begin
    forever begin
      @(chk_ev);
      if (exp_q.size() > 0) check(tag_q.pop_front(), exp_q.pop_front());
    end
  end

  task automatic push_exp(input string tag, input bit exp);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    -> chk_ev;
    #0.5;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_sys);
  endtask

  // Driver: one shift through input A or B, with the serial bit given.
  task automatic do_shift(input bit use_b, input bit sbit, input string tag);
    bit exp;
    ser_in = sbit;
    stream.push_back(sbit);
    if (use_b) shclk_b = 1'b1; else shclk_a = 1'b1;
    void'(stream.pop_front());
    exp = stream[0];
    wait_neg(3);
    push_exp(tag, exp);
    wait_neg(2);
    push_exp("R6 held high, no extra shift", exp);
    if (use_b) shclk_b = 1'b0; else shclk_a = 1'b0;
    wait_neg(3);
  endtask

  task automatic load_word(input logic [W-1:0] word);
    @(negedge clk_sys);
    load_n = 1'b0;
    par_in = word;
    wait_neg(2);
    load_n = 1'b1;
    par_in = ~word;
    stream.delete();
    for (int i = W - 1; i >= 0; i--) stream.push_back(word[i]);
    wait_neg(1);
  endtask

  initial begin
    rst_sys_n = 1'b1;
    par_in    = '0;
    ser_in    = 1'b0;
    load_n    = 1'b1;
    shclk_a   = 1'b0;
    shclk_b   = 1'b0;
    #1 rst_sys_n = 1'b0;
    wait_neg(3);
    rst_sys_n = 1'b1;
    wait_neg(4);

    // R1: cleared after reset.
    check("R1 reset state", 1'b0);

    // R2: during load the output follows the bus with no clock edge.
    load_n = 1'b0;
    par_in = 8'hB2;
    #0.5 check("R2 follow bus top bit without edge", 1'b1);
    par_in = 8'h32;
    #0.5 check("R2 follow bus change without edge", 1'b0);
    par_in = 8'hB2;
    wait_neg(2);
    load_n = 1'b1;
    par_in = 8'h00;
    wait_neg(2);
    check("R2 word held after release", 1'b1);
    stream.delete();
    for (int i = W - 1; i >= 0; i--) stream.push_back(par_in[i] | (8'hB2 >> i) & 1'b1);

    // R4: first shift, latency of three system edges.
    ser_in  = 1'b1;
    stream.push_back(1'b1);
    void'(stream.pop_front());
    shclk_a = 1'b1;
    wait_neg(2);
    check("R4 unchanged after two edges", 1'b1);
    wait_neg(1);
    check("R4 R3 changed at third edge (P6)", stream[0]);
    wait_neg(2);
    check("R6 held high no extra shift", stream[0]);
    shclk_a = 1'b0;
    wait_neg(3);

    // R3 / R5: rest of the byte and then serial bits, alternating inputs.
    begin
      bit sbits[9] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
      for (int k = 0; k < 9; k++) begin
        if (k % 2 == 0) do_shift(1'b1, sbits[k], "R5 R3 shift via input B");
        else            do_shift(1'b0, sbits[k], "R3 shift via input A");
      end
    end

    // R6: overlapping inputs give a single shift.
    load_word(8'hC3);
    check("R2 loaded C3 top bit", 1'b1);
    ser_in  = 1'b0;
    shclk_a = 1'b1;
    wait_neg(3);
    check("R6 first shift on overlap (P6 of C3)", 1'b1);
    shclk_b = 1'b1;
    wait_neg(4);
    check("R6 second input rising while first high", 1'b1);
    shclk_a = 1'b0;
    wait_neg(4);
    check("R6 first input falls, other still high", 1'b1);
    shclk_b = 1'b0;
    wait_neg(3);
    shclk_a = 1'b1;
    wait_neg(3);
    check("R6 fresh edge shifts again (P5 of C3)", 1'b0);
    shclk_a = 1'b0;
    wait_neg(3);

    // R7: edge during load is discarded, not deferred.
    @(negedge clk_sys);
    load_n = 1'b0;
    par_in = 8'h5A;
    wait_neg(2);
    shclk_a = 1'b1;
    wait_neg(4);
    check("R7 R2 during load with shift clock high", 1'b0);
    load_n = 1'b1;
    par_in = 8'hFF;
    wait_neg(5);
    check("R7 no deferred shift after release", 1'b0);
    shclk_a = 1'b0;
    wait_neg(3);
    ser_in  = 1'b0;
    shclk_b = 1'b1;
    wait_neg(3);
    check("R7 R3 next shift shows P6 of 5A", 1'b1);
    shclk_b = 1'b0;
    wait_neg(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule